// File: doc/BRIEF.md
# Multi-mode parallel port data FIFO

This block is the byte-wide data FIFO that sits behind a single host register address of a parallel port. A 3-bit mode input and a stored direction bit decide which side fills the FIFO and which side drains it. The modes are forward-only compatible transfer, bidirectional ECP data transfer, and a test mode in which the host alone reads and writes the FIFO. The peripheral-side line handshakes are outside the block. They appear only as single-cycle push and pop strobes.

The host writes the control byte through `ctl_we`/`ctl_wdata`, and only the direction bit is kept. The block reports full, empty and a service flag. The service flag watches occupancy against a write threshold (free space) while the port sends and against a read threshold (filled bytes) while it receives. In test mode the FIFO never stalls: writes to a full FIFO are lost, and reads from an empty FIFO repeat the previous byte. This lets software probe the FIFO depth and the thresholds.

Top module: `pport_fifo`

## Requirements
- R1: After reset the FIFO is empty, `full` and `svc_irq` are 0, `host_rdata` is 00h and the stored direction is 0.
- R2: In any cycle where `mode` differs from its value in the previous cycle, all transfers are blocked and the FIFO is flushed. From the next cycle, `empty`=1, `svc_irq`=0 and `host_rdata`=00h.
- R3: In modes 000 and 010 the stored direction is ignored and the effective direction is output. In every other mode, direction 0 means output and direction 1 means input.
- R4: `ctl_rdata` is {2'b00, dir, 5'b00000}, where dir is bit 5 of the last control write. Bits 7 and 6 always read as 0 whatever is written.
- R5: Bytes always leave the FIFO from its head in the order they entered (44h, 33h, 22h in gives 44h, 33h, 22h out).
- R6: In mode 010 the host writes the FIFO and `per_pop` drains it. `per_push` and `host_rd` have no effect there.
- R7: In mode 011 with output direction, the host writes and `per_pop` drains. With input direction, `per_push` fills and `host_rd` drains. The strobes of the other pair have no effect.
- R8: In mode 110 `host_wr` and `host_rd` both work in either direction, and the peripheral strobes have no effect. Modes other than 010, 011 and 110 accept no transfer.
- R9: A push into a full FIFO is discarded, and `full` stays 1. A pop in the same cycle does not free room for it.
- R10: An accepted `host_rd` on a non-empty FIFO puts the head byte on `host_rdata` in the next cycle. A `host_rd` on an empty FIFO leaves `host_rdata` at the last byte read, and `empty` stays 1.
- R11: With effective output direction, `svc_irq` sets when a pop brings occupancy down to DEPTH-WR_FREE (8). It clears when occupancy rises above that level.
- R12: With effective input direction, `svc_irq` sets when a push brings occupancy up to RD_FILL (8). It clears when occupancy falls below that level.
- R13: A control write that changes the direction bit clears `svc_irq`.
- R14: `per_rdata` shows the head byte while the FIFO is not empty and 00h while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Port mode field |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte; bit 5 is direction |
| ctl_rdata | output | 8 | Control byte as read back |
| host_wr | input | 1 | Host write strobe to FIFO |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from FIFO |
| host_rdata | output | 8 | Last byte read by host |
| per_push | input | 1 | Peripheral-side fill strobe |
| per_wdata | input | 8 | Peripheral-side fill byte |
| per_pop | input | 1 | Peripheral-side drain strobe |
| per_rdata | output | 8 | Head byte toward the peripheral |
| full | output | 1 | FIFO holds DEPTH bytes |
| empty | output | 1 | FIFO holds no byte |
| svc_irq | output | 1 | Service threshold flag |

## Verification
Every state change is due one clock after the strobe that caused it. Flags, `host_rdata`, `ctl_rdata` and the head byte on `per_rdata` all come from registers updated at that edge. A mode change takes effect one edge later and suppresses the transfers of that same cycle. The bench holds its inputs across each rising edge and advances its queue model right after the edge. It compares every output 1 ns later, well before the next edge, so every cycle is checked once against the state that cycle should produce. Directed phases cover each requirement, and a long mixed phase exercises mode switches, direction flips and simultaneous strobes.

// File: rtl/pport_fifo.sv
module pport_fifo #(
  parameter int DEPTH   = 16,
  parameter int WR_FREE = 8,
  parameter int RD_FILL = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  input  logic       per_push,
  input  logic [7:0] per_wdata,
  input  logic       per_pop,
  output logic [7:0] per_rdata,
  output logic       full,
  output logic       empty,
  output logic       svc_irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int WLVL = DEPTH - WR_FREE;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n;
  logic [2:0]    mode_q;
  logic          dir_q;
  logic [7:0]    last_q;
  logic          svc_q;

  logic unused_ok;
  assign unused_ok = ^{ctl_wdata[7:6], ctl_wdata[4:0]};

  wire flush  = mode != mode_q;
  wire m_cpt  = mode == 3'b010;
  wire m_ecp  = mode == 3'b011;
  wire m_tst  = mode == 3'b110;
  wire eff_in = dir_q & (mode != 3'b000) & ~m_cpt;
  wire is_full  = cnt == CW'(DEPTH);
  wire is_empty = cnt == '0;

  wire do_hw = host_wr  & ~is_full  & ~flush & (m_cpt | m_tst | (m_ecp & ~eff_in));
  wire do_pu = per_push & ~is_full  & ~flush & m_ecp & eff_in;
  wire do_hr = host_rd  & ~is_empty & ~flush & (m_tst | (m_ecp & eff_in));
  wire do_pp = per_pop  & ~is_empty & ~flush & (m_cpt | (m_ecp & ~eff_in));
  wire push  = do_hw | do_pu;
  wire pop   = do_hr | do_pp;
  wire [7:0] push_data = do_hw ? host_wdata : per_wdata;
  wire dir_chg = ctl_we & (ctl_wdata[5] != dir_q);

  assign cnt_n = cnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk)
    if (push) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; mode_q <= 3'b000; last_q <= 8'h00;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0; mode_q <= mode; last_q <= 8'h00;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_hr) last_q <= mem[rp];
      cnt <= cnt_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dir_q <= 1'b0;
    else if (ctl_we) dir_q <= ctl_wdata[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) svc_q <= 1'b0;
    else if (flush || dir_chg) svc_q <= 1'b0;
    else if (!eff_in) begin
      if (cnt_n < cnt && cnt_n == CW'(WLVL)) svc_q <= 1'b1;
      else if (cnt_n > CW'(WLVL))            svc_q <= 1'b0;
    end else begin
      if (cnt_n > cnt && cnt_n == CW'(RD_FILL)) svc_q <= 1'b1;
      else if (cnt_n < CW'(RD_FILL))            svc_q <= 1'b0;
    end

  assign ctl_rdata  = {2'b00, dir_q, 5'b00000};
  assign host_rdata = last_q;
  assign per_rdata  = is_empty ? 8'h00 : mem[rp];
  assign full       = is_full;
  assign empty      = is_empty;
  assign svc_irq    = svc_q;
endmodule

module pport_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic [2:0] mode_q,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       per_push,
  input logic       full,
  input logic       empty,
  input logic       svc_irq
);
  // R1
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  // R2
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (empty && !svc_irq && host_rdata == 8'h00));
  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110 && mode_q == 3'b110 && full && host_wr && !host_rd) |=> full);
  // R10
  empty_reread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110 && mode_q == 3'b110 && empty && host_rd && !host_wr)
      |=> ($stable(host_rdata) && empty));
  // R6
  cpt_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 && mode_q == 3'b010 && empty && per_push && !host_wr) |=> empty);
endmodule

bind pport_fifo pport_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mode_q(mode_q),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
  .per_push(per_push), .full(full), .empty(empty), .svc_irq(svc_irq)
);

// File: tb/sim_pport_fifo.sv
`timescale 1ns/1ps
module sim_pport_fifo;
  localparam int DEPTH = 16;
  localparam int WLVL  = 8;
  localparam int RLVL  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic ctl_we = 0, host_wr = 0, host_rd = 0, per_push = 0, per_pop = 0;
  logic [7:0] ctl_wdata = 0, host_wdata = 0, per_wdata = 0;
  logic [7:0] ctl_rdata, host_rdata, per_rdata;
  logic full, empty, svc_irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pport_fifo u0 (.*);

  logic [7:0] q[$];
  logic [2:0] m_mode = 3'b000;
  logic m_dir = 0, m_svc = 0;
  logic [7:0] m_last = 0;

  task automatic model_step();
    bit effin, hw, hr, pp, pu, chg;
    int old;
    chg = ctl_we && (ctl_wdata[5] != m_dir);
    if (mode != m_mode) begin
      q.delete(); m_svc = 0; m_last = 0; m_mode = mode;
    end else begin
      effin = m_dir && mode != 3'd0 && mode != 3'd2;
      old = q.size();
      hw = host_wr && old < DEPTH && (mode == 3'd2 || mode == 3'd6 || (mode == 3'd3 && !effin));
      pu = per_push && old < DEPTH && mode == 3'd3 && effin;
      hr = host_rd && old > 0 && (mode == 3'd6 || (mode == 3'd3 && effin));
      pp = per_pop && old > 0 && (mode == 3'd2 || (mode == 3'd3 && !effin));
      if (hr) m_last = q[0];
      if (hr || pp) void'(q.pop_front());
      if (hw) q.push_back(host_wdata);
      if (pu) q.push_back(per_wdata);
      if (chg) m_svc = 0;
      else if (!effin) begin
        if (q.size() < old && q.size() == WLVL) m_svc = 1;
        else if (q.size() > WLVL) m_svc = 0;
      end else begin
        if (q.size() > old && q.size() == RLVL) m_svc = 1;
        else if (q.size() < RLVL) m_svc = 0;
      end
    end
    if (ctl_we) m_dir = ctl_wdata[5];
  endtask

  task automatic compare(string tag);
    logic [7:0] e_per, e_ctl;
    e_per = (q.size() == 0) ? 8'h00 : q[0];
    e_ctl = {2'b00, m_dir, 5'b0};
    vectors++;
    if (empty !== (q.size() == 0) || full !== (q.size() == DEPTH)) begin
      errors++; $display("FAIL %s flags e/f act %b%b exp %b%b", tag, empty, full, q.size() == 0, q.size() == DEPTH);
    end
    if (svc_irq !== m_svc) begin
      errors++; $display("FAIL %s svc_irq act %b exp %b", tag, svc_irq, m_svc);
    end
    if (host_rdata !== m_last) begin
      errors++; $display("FAIL %s host_rdata act %h exp %h", tag, host_rdata, m_last);
    end
    if (per_rdata !== e_per) begin
      errors++; $display("FAIL %s per_rdata act %h exp %h", tag, per_rdata, e_per);
    end
    if (ctl_rdata !== e_ctl) begin
      errors++; $display("FAIL %s ctl_rdata act %h exp %h", tag, ctl_rdata, e_ctl);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
    ctl_we = 0; host_wr = 0; host_rd = 0; per_push = 0; per_pop = 0;
  endtask

  task automatic hw(logic [7:0] b, string tag); host_wr = 1; host_wdata = b; tick(tag); endtask
  task automatic hr(string tag); host_rd = 1; tick(tag); endtask
  task automatic pu(logic [7:0] b, string tag); per_push = 1; per_wdata = b; tick(tag); endtask
  task automatic pp(string tag); per_pop = 1; tick(tag); endtask
  task automatic setdir(logic d, string tag); ctl_we = 1; ctl_wdata = {2'b11, d, 5'h1f}; tick(tag); endtask
  task automatic setmode(logic [2:0] m, string tag); mode = m; tick(tag); tick(tag); endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    rst_n = 1;
    tick("R1 idle");
    // R4: upper bits ignored, direction bit kept
    setdir(1, "R4 dir1");
    setdir(0, "R4 dir0");
    // R8/R5: test mode order
    setmode(3'b110, "R2 enter test");
    hw(8'h44, "R5"); hw(8'h33, "R5"); hw(8'h22, "R5");
    hr("R5"); hr("R5"); hr("R5");
    // R10: empty reread
    hr("R10"); hr("R10");
    // R9 and R11: fill past full, then drain in output direction
    for (int i = 0; i < DEPTH + 3; i++) hw(8'(8'h80 + i), "R9 fill");
    hw(8'hEE, "R9 full write"); host_rd = 1; hw(8'hEF, "R9 pop+push full");
    for (int i = 0; i < DEPTH; i++) hr("R11 drain");
    hr("R10 empty");
    // R12: input direction in test mode
    setdir(1, "R13 dir");
    for (int i = 0; i < 10; i++) hw(8'(i), "R12 fill");
    for (int i = 0; i < 4; i++) hr("R12 drain");
    per_push = 1; per_pop = 1; hw(8'h55, "R8 per ignored");
    // R13: direction change clears svc
    for (int i = 0; i < 3; i++) hw(8'(i), "R13 fill");
    setdir(0, "R13 clear");
    // R2: mode change flushes
    setmode(3'b010, "R2 flush");
    // R6/R3: compatible mode ignores dir
    setdir(1, "R3 dir ignored");
    pu(8'h11, "R6 push ignored");
    hw(8'hA1, "R6"); hw(8'hA2, "R6"); hr("R6 rd ignored");
    pp("R14"); pp("R14"); pp("R14 empty");
    for (int i = 0; i < 12; i++) hw(8'(8'h30 + i), "R11 cpt");
    for (int i = 0; i < 6; i++) pp("R11 cpt drain");
    // R7: ECP both directions
    setmode(3'b011, "R2 ecp");
    for (int i = 0; i < 10; i++) pu(8'(8'hC0 + i), "R7 in");
    hw(8'h99, "R7 hw ignored"); pp("R7 pp ignored");
    for (int i = 0; i < 5; i++) hr("R7 in read");
    setdir(0, "R7 out");
    hw(8'h77, "R7 out"); pu(8'h66, "R7 pu ignored"); hr("R7 hr ignored");
    for (int i = 0; i < 8; i++) pp("R7 out drain");
    setmode(3'b001, "R8 idle mode");
    hw(8'h12, "R8 no xfer"); pp("R8 no xfer");
    // mixed phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 99) == 0) begin
        case ($urandom_range(0, 3))
          0: mode = 3'b010;
          1: mode = 3'b011;
          2: mode = 3'b110;
          default: mode = 3'b000;
        endcase
      end
      ctl_we = ($urandom_range(0, 49) == 0);
      ctl_wdata = 8'($urandom);
      host_wr = $urandom_range(0, 1); host_wdata = 8'($urandom);
      host_rd = $urandom_range(0, 1);
      per_push = $urandom_range(0, 1); per_wdata = 8'($urandom);
      per_pop = $urandom_range(0, 1);
      tick("R5 mixed");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule